// File: doc/BRIEF.md
# Command Engine Logic Unit

This block is the arithmetic and logic stage of a multi-threaded command engine. Every hardware thread has its own small bank of scratch registers. All threads use the same register numbers, but each thread's values are stored separately. A single command names the issuing thread, a destination register, an operation code and two operand descriptors. Each operand is either a register of the issuing thread or a 16-bit constant. The unit computes the result and writes it into the issuing thread's destination register. The usual first step of a command sequence is to load a constant into a register. That register is then used as a value, a mask or an upper address word by the read and write commands that follow.

A command is accepted on any clock edge where `cmd_valid` is high. There is no back-pressure. The result is held in a write-back stage for one cycle and then committed to the bank. An operand that reads a register with a commit still pending receives the pending value. A stream of dependent commands therefore behaves as if each command completed before the next one started. Unassigned operation codes are rejected: a one-cycle error flag is raised and no register changes. A combinational read-out port shows any register of any thread.

Top module: `cmd_logic_unit`

## Requirements
- R1: Reset (synchronous, active high) clears every register of every thread to zero.
- R2: A command writes only the destination register of its own thread. Registers with the same number in other threads keep their values.
- R3: An operand with its register flag set reads the issuing thread's register selected by the low two bits of its 16-bit field. The upper field bits are ignored. With the flag clear, the field is a constant zero-extended to 32 bits.
- R4: Code 1 adds, code 2 subtracts (left minus right) and code 3 multiplies. All three wrap modulo 2^32, and multiply keeps the low 32 bits of the product.
- R5: Code 8 is bitwise XOR, code 10 is OR and code 11 is AND. Code 9 returns the bitwise inverse of the right operand and ignores the left operand.
- R6: Code 12 shifts the left operand left and code 13 shifts it right logically. The shift amount is the low five bits of the right operand.
- R7: Code 0 copies the right operand into the destination register.
- R8: A command accepted on edge k is visible on the read-out port after edge k+1 and not before. `err_illegal` is high only in the cycle after an edge that accepted an illegal command.
- R9: Codes 4 to 7, 14 and 15 are illegal. They raise `err_illegal` for one cycle and change no register.
- R10: When commands are issued on consecutive cycles, a command that reads the destination of the previous command sees the new value.
- R11: `rd_data` always equals the register selected by `rd_thread` and `rd_index`, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present and is accepted on this edge |
| cmd_thread | input | 2 | Issuing thread |
| cmd_dst | input | 2 | Destination register number |
| cmd_op | input | 4 | Operation code |
| cmd_lhs_is_reg | input | 1 | Left operand is a register (1) or a constant (0) |
| cmd_lhs_field | input | 16 | Left operand register number or constant |
| cmd_rhs_is_reg | input | 1 | Right operand is a register (1) or a constant (0) |
| cmd_rhs_field | input | 16 | Right operand register number or constant |
| rd_thread | input | 2 | Read-out thread select |
| rd_index | input | 2 | Read-out register select |
| rd_data | output | 32 | Selected register value |
| err_illegal | output | 1 | Illegal operation code seen on the previous edge |

## Verification
A command accepted on a rising edge is due on the read-out port two edges later. The error flag is due one edge later. The bench's reference model applies each command on the edge that accepts it, but delays the visible copy of the register by one further edge. It then compares the port and the flag at every falling edge, so any early or late commit is reported. Directed reads are placed at the falling edge after the idle cycle that follows a command. The timing and illegal-code cases also sample in the cycle straight after acceptance, where the old value and a raised flag are expected.

// File: rtl/clu_pkg.sv
package clu_pkg;

    localparam int DATA_W  = 32;
    localparam int IMM_W   = 16;
    localparam int OP_W    = 4;
    localparam int SHAMT_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_MUL  = 4'd3,
        OP_XOR  = 4'd8,
        OP_INV  = 4'd9,
        OP_OR   = 4'd10,
        OP_AND  = 4'd11,
        OP_SHL  = 4'd12,
        OP_SHR  = 4'd13
    } clu_op_e;

    typedef struct packed {
        logic             is_reg;
        logic [IMM_W-1:0] field;
    } clu_operand_t;

    function automatic logic clu_op_legal(logic [OP_W-1:0] code);
        logic ok;
        case (code)
            4'd0, 4'd1, 4'd2, 4'd3,
            4'd8, 4'd9, 4'd10, 4'd11,
            4'd12, 4'd13: ok = 1'b1;
            default:      ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic [DATA_W-1:0] clu_compute(clu_op_e op,
                                                      logic [DATA_W-1:0] a,
                                                      logic [DATA_W-1:0] b);
        logic [DATA_W-1:0] r;
        case (op)
            OP_LOAD: r = b;
            OP_ADD:  r = a + b;
            OP_SUB:  r = a - b;
            OP_MUL:  r = a * b;
            OP_XOR:  r = a ^ b;
            OP_INV:  r = ~b;
            OP_OR:   r = a | b;
            OP_AND:  r = a & b;
            OP_SHL:  r = a << b[SHAMT_W-1:0];
            OP_SHR:  r = a >> b[SHAMT_W-1:0];
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clu_regbank.sv
module clu_regbank #(
    parameter int NUM_THREADS = 4,
    parameter int NUM_REGS    = 4,
    parameter int NUM_RD      = 3,
    localparam int TID_W  = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int RIDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      wr_en,
    input  logic [TID_W-1:0]                          wr_thread,
    input  logic [RIDX_W-1:0]                         wr_index,
    input  logic [clu_pkg::DATA_W-1:0]                wr_data,
    input  logic [NUM_RD-1:0][TID_W-1:0]              rd_thread,
    input  logic [NUM_RD-1:0][RIDX_W-1:0]             rd_index,
    output logic [NUM_RD-1:0][clu_pkg::DATA_W-1:0]    rd_data
);
    import clu_pkg::*;

    logic [DATA_W-1:0] store [NUM_THREADS][NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < NUM_THREADS; t++) begin
                for (int i = 0; i < NUM_REGS; i++) begin
                    store[t][i] <= '0;
                end
            end
        end else if (wr_en) begin
            store[wr_thread][wr_index] <= wr_data;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        assign rd_data[p] = store[rd_thread[p]][rd_index[p]];
    end

endmodule

// File: rtl/clu_operand_sel.sv
module clu_operand_sel #(
    parameter int NUM_THREADS = 4,
    parameter int NUM_REGS    = 4,
    localparam int TID_W  = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int RIDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  clu_pkg::clu_operand_t        opnd,
    input  logic [TID_W-1:0]             cur_thread,
    output logic [RIDX_W-1:0]            bank_index,
    input  logic [clu_pkg::DATA_W-1:0]   bank_data,
    input  logic                         fwd_valid,
    input  logic [TID_W-1:0]             fwd_thread,
    input  logic [RIDX_W-1:0]            fwd_index,
    input  logic [clu_pkg::DATA_W-1:0]   fwd_data,
    output logic [clu_pkg::DATA_W-1:0]   value
);
    import clu_pkg::*;

    logic              fwd_hit;
    logic [DATA_W-1:0] reg_value;

    assign bank_index = opnd.field[RIDX_W-1:0];
    assign fwd_hit    = fwd_valid && (fwd_thread == cur_thread) && (fwd_index == bank_index);
    assign reg_value  = fwd_hit ? fwd_data : bank_data;

    always_comb begin
        if (opnd.is_reg) begin
            value = reg_value;
        end else begin
            value = {{(DATA_W-IMM_W){1'b0}}, opnd.field};
        end
    end

endmodule

// File: rtl/clu_alu.sv
module clu_alu (
    input  logic [clu_pkg::OP_W-1:0]   op_code,
    input  logic [clu_pkg::DATA_W-1:0] lhs,
    input  logic [clu_pkg::DATA_W-1:0] rhs,
    output logic [clu_pkg::DATA_W-1:0] result,
    output logic                       legal
);
    import clu_pkg::*;

    assign legal  = clu_op_legal(op_code);
    assign result = clu_compute(clu_op_e'(op_code), lhs, rhs);

endmodule

// File: rtl/cmd_logic_unit.sv
module cmd_logic_unit #(
    parameter int NUM_THREADS = 4,
    parameter int NUM_REGS    = 4,
    localparam int TID_W  = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int RIDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int NUM_OPND = 2,
    localparam int NUM_RD   = NUM_OPND + 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cmd_valid,
    input  logic [TID_W-1:0]              cmd_thread,
    input  logic [RIDX_W-1:0]             cmd_dst,
    input  logic [clu_pkg::OP_W-1:0]      cmd_op,
    input  logic                          cmd_lhs_is_reg,
    input  logic [clu_pkg::IMM_W-1:0]     cmd_lhs_field,
    input  logic                          cmd_rhs_is_reg,
    input  logic [clu_pkg::IMM_W-1:0]     cmd_rhs_field,
    input  logic [TID_W-1:0]              rd_thread,
    input  logic [RIDX_W-1:0]             rd_index,
    output logic [clu_pkg::DATA_W-1:0]    rd_data,
    output logic                          err_illegal
);
    import clu_pkg::*;

    // write-back stage, committed to the bank one edge after acceptance
    logic              wb_valid;
    logic [TID_W-1:0]  wb_thread;
    logic [RIDX_W-1:0] wb_index;
    logic [DATA_W-1:0] wb_data;
    logic              err_q;
    logic              wb_fire;

    clu_operand_t                   opnd     [NUM_OPND];
    logic [DATA_W-1:0]              opnd_val [NUM_OPND];
    logic [NUM_RD-1:0][TID_W-1:0]   bank_thr;
    logic [NUM_RD-1:0][RIDX_W-1:0]  bank_idx;
    logic [NUM_RD-1:0][DATA_W-1:0]  bank_dat;

    logic [DATA_W-1:0] alu_result;
    logic              alu_legal;
    logic              accept_ok;
    logic              accept_bad;

    assign opnd[0] = '{is_reg: cmd_lhs_is_reg, field: cmd_lhs_field};
    assign opnd[1] = '{is_reg: cmd_rhs_is_reg, field: cmd_rhs_field};

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        assign bank_thr[g] = cmd_thread;
        clu_operand_sel #(
            .NUM_THREADS (NUM_THREADS),
            .NUM_REGS    (NUM_REGS)
        ) u_sel (
            .opnd       (opnd[g]),
            .cur_thread (cmd_thread),
            .bank_index (bank_idx[g]),
            .bank_data  (bank_dat[g]),
            .fwd_valid  (wb_valid),
            .fwd_thread (wb_thread),
            .fwd_index  (wb_index),
            .fwd_data   (wb_data),
            .value      (opnd_val[g])
        );
    end

    assign bank_thr[NUM_OPND] = rd_thread;
    assign bank_idx[NUM_OPND] = rd_index;
    assign rd_data            = bank_dat[NUM_OPND];

    clu_regbank #(
        .NUM_THREADS (NUM_THREADS),
        .NUM_REGS    (NUM_REGS),
        .NUM_RD      (NUM_RD)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wb_valid),
        .wr_thread (wb_thread),
        .wr_index  (wb_index),
        .wr_data   (wb_data),
        .rd_thread (bank_thr),
        .rd_index  (bank_idx),
        .rd_data   (bank_dat)
    );

    clu_alu u_alu (
        .op_code (cmd_op),
        .lhs     (opnd_val[0]),
        .rhs     (opnd_val[1]),
        .result  (alu_result),
        .legal   (alu_legal)
    );

    assign accept_ok  = cmd_valid && alu_legal;
    assign accept_bad = cmd_valid && !alu_legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid  <= 1'b0;
            wb_thread <= '0;
            wb_index  <= '0;
            wb_data   <= '0;
            err_q     <= 1'b0;
        end else begin
            wb_valid <= accept_ok;
            err_q    <= accept_bad;
            if (accept_ok) begin
                wb_thread <= cmd_thread;
                wb_index  <= cmd_dst;
                wb_data   <= alu_result;
            end
        end
    end

    assign wb_fire     = wb_valid;
    assign err_illegal = err_q;

endmodule

// File: rtl/clu_checker.sv
module clu_checker (
    input logic                       clk,
    input logic                       rst,
    input logic                       cmd_valid,
    input logic [clu_pkg::OP_W-1:0]   cmd_op,
    input logic                       err_illegal,
    input logic                       wr_fire,
    input logic [clu_pkg::DATA_W-1:0] rd_data
);
    import clu_pkg::*;

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rd_data == '0)); // R1

    AST_ILLEGAL_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !clu_op_legal(cmd_op)) |=> err_illegal); // R9

    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !clu_op_legal(cmd_op)) |=> !wr_fire); // R9

    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        err_illegal |-> $past(cmd_valid)); // R8

    AST_WRITE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        wr_fire |-> $past(cmd_valid)); // R8

    AST_NO_ERR_AND_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(err_illegal && wr_fire)); // R9

endmodule

bind cmd_logic_unit clu_checker u_clu_checker (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .err_illegal (err_illegal),
    .wr_fire     (wb_fire),
    .rd_data     (rd_data)
);

// File: tb/cmd_logic_unit_tb.sv
`timescale 1ns/1ps
module cmd_logic_unit_tb;

    localparam int NT    = 4;
    localparam int NR    = 4;
    localparam real CLK_HALF = 4.0;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd_thread;
    logic [1:0]  cmd_dst;
    logic [3:0]  cmd_op;
    logic        cmd_lhs_is_reg;
    logic [15:0] cmd_lhs_field;
    logic        cmd_rhs_is_reg;
    logic [15:0] cmd_rhs_field;
    logic [1:0]  rd_thread;
    logic [1:0]  rd_index;
    logic [31:0] rd_data;
    logic        err_illegal;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    cmd_logic_unit u_dut (
        .clk            (clk),
        .rst            (rst),
        .cmd_valid      (cmd_valid),
        .cmd_thread     (cmd_thread),
        .cmd_dst        (cmd_dst),
        .cmd_op         (cmd_op),
        .cmd_lhs_is_reg (cmd_lhs_is_reg),
        .cmd_lhs_field  (cmd_lhs_field),
        .cmd_rhs_is_reg (cmd_rhs_is_reg),
        .cmd_rhs_field  (cmd_rhs_field),
        .rd_thread      (rd_thread),
        .rd_index       (rd_index),
        .rd_data        (rd_data),
        .err_illegal    (err_illegal)
    );

    // ---------------- reference model ----------------
    logic [31:0] arch [NT][NR];   // state as if every command completed at once
    logic [31:0] vis  [NT][NR];   // state visible at the read-out port
    bit          pend_v;
    int          pend_t, pend_i;
    logic [31:0] pend_d;
    bit          exp_err;
    logic [31:0] ma, mb;

    function automatic bit ref_ok(int code);
        return (code <= 3) || (code >= 8 && code <= 13);
    endfunction

    function automatic logic [31:0] ref_calc(int code, logic [31:0] a, logic [31:0] b);
        longint unsigned p;
        if (code == 0) return b;
        if (code == 1) return a + b;
        if (code == 2) return a - b;
        if (code == 3) begin
            p = longint'(a) * longint'(b);
            return p[31:0];
        end
        if (code == 8)  return a ^ b;
        if (code == 9)  return ~b;
        if (code == 10) return a | b;
        if (code == 11) return a & b;
        if (code == 12) return a << b[4:0];
        return a >> b[4:0];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < NT; t++)
                for (int i = 0; i < NR; i++) begin
                    arch[t][i] = '0;
                    vis[t][i]  = '0;
                end
            pend_v  = 1'b0;
            exp_err = 1'b0;
        end else begin
            if (pend_v) vis[pend_t][pend_i] = pend_d;
            pend_v  = 1'b0;
            exp_err = 1'b0;
            if (cmd_valid) begin
                ma = cmd_lhs_is_reg ? arch[cmd_thread][cmd_lhs_field[1:0]] : {16'h0, cmd_lhs_field};
                mb = cmd_rhs_is_reg ? arch[cmd_thread][cmd_rhs_field[1:0]] : {16'h0, cmd_rhs_field};
                if (ref_ok(int'(cmd_op))) begin
                    pend_d = ref_calc(int'(cmd_op), ma, mb);
                    pend_t = int'(cmd_thread);
                    pend_i = int'(cmd_dst);
                    pend_v = 1'b1;
                    arch[pend_t][pend_i] = pend_d;
                end else begin
                    exp_err = 1'b1;
                end
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            check("R11 readout vs model", rd_data, vis[rd_thread][rd_index]);
            check("R8 error flag vs model", {31'b0, err_illegal}, {31'b0, exp_err});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic issue(int t, int d, int op, bit lr, int lf, bit rr, int rf);
        @(negedge clk);
        cmd_valid      = 1'b1;
        cmd_thread     = t[1:0];
        cmd_dst        = d[1:0];
        cmd_op         = op[3:0];
        cmd_lhs_is_reg = lr;
        cmd_lhs_field  = lf[15:0];
        cmd_rhs_is_reg = rr;
        cmd_rhs_field  = rf[15:0];
    endtask

    task automatic idle();
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic read_chk(int t, int i, logic [31:0] exp, string tag);
        @(negedge clk);
        rd_thread = t[1:0];
        rd_index  = i[1:0];
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_HALF * 2.0 * 100000.0);
        checks++;
        errors++;
        $display("FAIL R8: watchdog expired, actual=hung expected=completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_thread = '0; cmd_dst = '0; cmd_op = '0;
        cmd_lhs_is_reg = 1'b0; cmd_lhs_field = '0; cmd_rhs_is_reg = 1'b0; cmd_rhs_field = '0;
        rd_thread = '0; rd_index = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: every register zero after reset
        for (int t = 0; t < NT; t++)
            for (int i = 0; i < NR; i++)
                read_chk(t, i, 32'h0, "R1 reset value");

        // R7 assign, R2 banking
        issue(0, 0, 0, 0, 16'h1234, 0, 16'h1234); idle();
        read_chk(0, 0, 32'h0000_1234, "R7 assign constant");
        read_chk(1, 0, 32'h0, "R2 other thread untouched");

        // R3 register operands, R4 wrap arithmetic
        issue(0, 1, 0, 0, 0, 0, 16'hFFFF); idle();
        issue(0, 2, 1, 1, 0, 1, 1); idle();
        read_chk(0, 2, 32'h0001_1233, "R4 add of two registers (R3)");
        issue(0, 3, 3, 1, 1, 1, 1); idle();
        read_chk(0, 3, 32'hFFFE_0001, "R4 multiply");
        issue(0, 3, 3, 1, 3, 1, 3); idle();
        read_chk(0, 3, 32'hFFFC_0001, "R4 multiply keeps low word");
        issue(1, 0, 2, 0, 0, 0, 1); idle();
        read_chk(1, 0, 32'hFFFF_FFFF, "R4 subtract wraps");
        read_chk(0, 0, 32'h0000_1234, "R2 thread 0 reg 0 kept");

        // R5 bitwise
        issue(1, 1, 9, 0, 16'hABCD, 0, 16'h00FF); idle();
        read_chk(1, 1, 32'hFFFF_FF00, "R5 invert ignores left");
        issue(1, 2, 8, 1, 0, 0, 16'h0F0F); idle();
        read_chk(1, 2, 32'hFFFF_F0F0, "R5 xor");
        issue(1, 3, 10, 0, 16'h00F0, 0, 16'h0F00); idle();
        read_chk(1, 3, 32'h0000_0FF0, "R5 or");
        issue(1, 3, 11, 1, 2, 1, 3); idle();
        read_chk(1, 3, 32'h0000_00F0, "R5 and");

        // R6 shifts
        issue(2, 0, 12, 0, 1, 0, 16'h0021); idle();
        read_chk(2, 0, 32'h0000_0002, "R6 shift amount low five bits");
        issue(2, 1, 12, 0, 16'h8000, 0, 16); idle();
        read_chk(2, 1, 32'h8000_0000, "R6 left shift");
        issue(2, 2, 13, 1, 1, 0, 31); idle();
        read_chk(2, 2, 32'h0000_0001, "R6 logical right shift");

        // R8 commit timing
        issue(2, 3, 0, 0, 0, 0, 16'h0055);
        @(negedge clk);
        cmd_valid = 1'b0; rd_thread = 2'd2; rd_index = 2'd3;
        #1 check("R8 not visible one edge after accept", rd_data, 32'h0);
        @(negedge clk);
        #1 check("R8 visible two edges after accept", rd_data, 32'h0000_0055);

        // R9 illegal codes
        issue(2, 0, 5, 0, 16'h7777, 0, 16'h7777);
        @(negedge clk);
        cmd_valid = 1'b0; rd_thread = 2'd2; rd_index = 2'd0;
        #1 check("R9 error raised", {31'b0, err_illegal}, 32'h1);
        @(negedge clk);
        #1 check("R9 error lasts one cycle", {31'b0, err_illegal}, 32'h0);
        check("R9 register unchanged", rd_data, 32'h0000_0002);
        issue(2, 0, 4, 0, 1, 0, 1);
        issue(2, 0, 7, 0, 1, 0, 1);
        issue(2, 0, 14, 0, 1, 0, 1);
        issue(2, 0, 15, 0, 1, 0, 1);
        idle();
        read_chk(2, 0, 32'h0000_0002, "R9 codes 4 7 14 15 write nothing");

        // R10 back-to-back dependence
        issue(3, 0, 0, 0, 0, 0, 7);
        issue(3, 0, 1, 1, 0, 0, 1);
        issue(3, 1, 3, 1, 0, 0, 3);
        idle();
        read_chk(3, 0, 32'h0000_0008, "R10 forwarded add");
        read_chk(3, 1, 32'h0000_0018, "R10 forwarded multiply");

        // R3 upper field bits ignored for register index
        issue(3, 2, 1, 1, 16'h0005, 0, 0); idle();
        read_chk(3, 2, 32'h0000_0018, "R3 index from low bits");

        // R11 readout across threads
        read_chk(1, 0, 32'hFFFF_FFFF, "R11 readout thread 1");
        read_chk(0, 1, 32'h0000_FFFF, "R11 readout thread 0");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule